// File: doc/BRIEF.md
# I2C EEPROM Slave Command Engine

This block is the serial-bus slave front end of a 2K x 8 nonvolatile memory model. A fast system clock oversamples the SCL and SDA lines. The block finds Start and Stop conditions and shifts in the control byte, the word address and any write data. It pulls SDA low through an open-drain enable when it acknowledges a byte or sends a zero data bit. An 11-bit address pointer stays valid from one transaction to the next. The upper three pointer bits come from the block-select field of the control byte. The lower eight bits come from the word address byte.

Write data goes, one byte at a time, to a page-write controller. That controller holds the page latches and carries out the self-timed write cycle. While the cycle runs it raises a busy input, and during that time the engine acknowledges nothing. Reads use a synchronous memory port with one clock of latency. The pointer always drives the read address, so the next byte is ready before it has to be shifted out.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The first byte after a Start is the control byte, sent MSB first: bits 7..4 are the device code, bits 3..1 the block select and bit 0 the direction (1 = read, 0 = write). The engine acknowledges it only when the code is 4'b1010. On any other code it acknowledges nothing, including later bytes, until the next Start.
- R2: SDA falling while SCL is high is a Start, and SDA rising while SCL is high is a Stop. The engine changes its SDA drive only while the synchronized SCL is low.
- R3: An acknowledged control byte loads its block-select bits into pointer bits 10..8. In a write transfer the next byte is acknowledged and loads pointer bits 7..0, and pw_open pulses.
- R4: Each later write byte is acknowledged and sent out on pw_we, with pw_addr set to the current pointer. After each byte, pointer bits 3..0 step up by one and wrap within the 16-byte page, while bits 10..4 stay the same.
- R5: A Stop at a byte boundary, after at least one acknowledged write data byte, gives exactly one pw_commit pulse. A Stop after only a control byte or a word address gives no pulse.
- R6: A repeated Start after the word address ends the write without a commit and keeps the loaded pointer, so a read control byte that follows returns the byte at that address (random read).
- R7: A read control byte returns the byte at the pointer, which is the last accessed address plus one, with bits 10..8 taken from the control byte (current-address read).
- R8: Read data goes out MSB first, with SDA pulled low for 0 bits. A master ACK (low) in the ninth bit brings the next sequential byte. A master NACK makes the engine release SDA and send nothing more until the next Start.
- R9: The sequential-read pointer steps across the full 11-bit space and wraps from 0x7FF to 0x000.
- R10: While wc_busy is high the engine acknowledges no byte, including a control byte with a matching code.
- R11: A Start in the middle of a byte aborts the transfer: no commit is issued and the engine goes back to control-byte reception.
- R12: After reset, sda_oe is low, the pointer is 0x000 and no pulse outputs are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pulls SDA low when high (open drain) |
| mem_addr | output | 11 | Address pointer, used as the read address |
| mem_rdata | input | 8 | Read data, valid one clock after mem_addr |
| pw_open | output | 1 | Pulse: new word address accepted, clear page latches |
| pw_we | output | 1 | Pulse: write byte to page latch |
| pw_addr | output | 11 | Target address of the latched byte |
| pw_wdata | output | 8 | Byte to latch |
| pw_commit | output | 1 | Pulse: start the internal write cycle |
| wc_busy | input | 1 | Internal write cycle in progress |

## Verification
The hardest state to reach is an aborted write. The engine must have taken a data byte into the page latches and moved its pointer, and then see a Start partway through the next byte. The stimulus clocks one full data byte and four bits of a second one, then issues a Start. It then reads back both the current-address byte and the first target address. This shows that the pointer moved but no commit happened. The busy window is reached by polling right after a Stop: the first control byte sent there must go without an acknowledge.

// File: rtl/i2c_eep_pkg.sv
package i2c_eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } eng_state_t;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_d <= scl_p[STAGES-1];
      sda_d <= sda_p[STAGES-1];
    end
  end

  assign scl_lvl   = scl_p[STAGES-1];
  assign sda_lvl   = sda_p[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  // R2: data edges while the clock is held high
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx #(
  parameter int W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   sample,
  input  logic                   bit_in,
  output logic [W-1:0]           data,
  output logic [$clog2(W+1)-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (sample) begin
      data  <= {data[W-2:0], bit_in};
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/eep_addr_ptr.sv
module eep_addr_ptr #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blk_load,
  input  logic [ADDR_W-9:0] blk_val,
  input  logic              lo_load,
  input  logic [7:0]        lo_val,
  input  logic              page_inc,
  input  logic              seq_inc,
  output logic [ADDR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (blk_load) begin
      ptr[ADDR_W-1:8] <= blk_val;                    // R3
    end else if (lo_load) begin
      ptr[7:0] <= lo_val;                            // R3
    end else if (page_inc) begin
      ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;     // R4 wrap in page
    end else if (seq_inc) begin
      ptr <= ptr + 1'b1;                             // R9 full wrap
    end
  end
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_eep_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              pw_open,
  output logic              pw_we,
  output logic [ADDR_W-1:0] pw_addr,
  output logic [7:0]        pw_wdata,
  output logic              pw_commit,
  input  logic              wc_busy
);
  localparam int BLK_W = ADDR_W - 8;
  localparam logic [3:0] BYTE_BITS = 4'd8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] rx_byte;
  logic [3:0] rx_cnt;
  logic [7:0] tx_sh;
  logic [3:0] tx_cnt;
  logic mst_ack, dirty;
  eng_state_t state, ack_next;
  logic [ADDR_W-1:0] ptr;

  logic rx_sample, rx_clr, byte_done, code_ok;
  logic blk_load, lo_load, page_inc, seq_inc, tx_load, commit_ok;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_s), .sda_lvl(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_byte_rx #(.W(8)) u_rx (
    .clk(clk), .rst(rst), .clr(rx_clr), .sample(rx_sample),
    .bit_in(sda_s), .data(rx_byte), .count(rx_cnt)
  );

  eep_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk(clk), .rst(rst), .blk_load(blk_load), .blk_val(rx_byte[BLK_W:1]),
    .lo_load(lo_load), .lo_val(rx_byte), .page_inc(page_inc),
    .seq_inc(seq_inc), .ptr(ptr)
  );

  always_comb begin
    logic bus_evt;
    bus_evt   = start_det | stop_det;
    rx_sample = scl_rise & ~bus_evt &
                (state == ST_CTRL || state == ST_ADDR || state == ST_WDATA);
    rx_clr    = start_det | (state == ST_ACK & scl_fall);
    byte_done = scl_fall & (rx_cnt == BYTE_BITS) & ~bus_evt;
    code_ok   = (rx_byte[7:4] == DEV_CODE) & ~wc_busy;      // R1, R10
    blk_load  = (state == ST_CTRL) & byte_done & code_ok;
    lo_load   = (state == ST_ADDR) & byte_done;
    page_inc  = (state == ST_WDATA) & byte_done;
    tx_load   = scl_fall & ~bus_evt &
                ((state == ST_ACK & ack_next == ST_RDATA) |
                 (state == ST_RACK & mst_ack));
    seq_inc   = tx_load;
    // R5, R11: commit only at a byte boundary after acknowledged data
    commit_ok = stop_det & dirty & (state == ST_WDATA) & (rx_cnt <= 4'd1);
  end

  assign mem_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ack_next  <= ST_IDLE;
      sda_oe    <= 1'b0;
      tx_sh     <= '0;
      tx_cnt    <= '0;
      mst_ack   <= 1'b0;
      dirty     <= 1'b0;
      pw_open   <= 1'b0;
      pw_we     <= 1'b0;
      pw_addr   <= '0;
      pw_wdata  <= '0;
      pw_commit <= 1'b0;
    end else begin
      pw_open   <= 1'b0;
      pw_we     <= 1'b0;
      pw_commit <= 1'b0;
      if (start_det) begin
        state  <= ST_CTRL;
        sda_oe <= 1'b0;
        dirty  <= 1'b0;
      end else if (stop_det) begin
        state     <= ST_IDLE;
        sda_oe    <= 1'b0;
        dirty     <= 1'b0;
        pw_commit <= commit_ok;
      end else if (tx_load) begin
        sda_oe <= ~mem_rdata[7];
        tx_sh  <= {mem_rdata[6:0], 1'b0};
        tx_cnt <= 4'd1;
        state  <= ST_RDATA;
      end else begin
        unique case (state)
          ST_CTRL: if (byte_done) begin
            if (code_ok) begin
              sda_oe   <= 1'b1;
              ack_next <= rx_byte[0] ? ST_RDATA : ST_ADDR;
              state    <= ST_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_ADDR: if (byte_done) begin
            sda_oe   <= 1'b1;
            pw_open  <= 1'b1;
            ack_next <= ST_WDATA;
            state    <= ST_ACK;
          end
          ST_WDATA: if (byte_done) begin
            sda_oe   <= 1'b1;
            pw_we    <= 1'b1;
            pw_addr  <= ptr;
            pw_wdata <= rx_byte;
            dirty    <= 1'b1;
            ack_next <= ST_WDATA;
            state    <= ST_ACK;
          end
          ST_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ack_next;
          end
          ST_RDATA: if (scl_fall) begin
            if (tx_cnt == BYTE_BITS) begin
              sda_oe <= 1'b0;
              state  <= ST_RACK;
            end else begin
              sda_oe <= ~tx_sh[7];
              tx_sh  <= {tx_sh[6:0], 1'b0};
              tx_cnt <= tx_cnt + 1'b1;
            end
          end
          ST_RACK: begin
            if (scl_rise) mst_ack <= ~sda_s;
            if (scl_fall) state <= ST_IDLE;     // R8 NACK path
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
module i2c_eeprom_slave_chk
  import i2c_eep_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sda_oe,
  input logic              scl_lvl,
  input eng_state_t        state,
  input logic [7:0]        rx_byte,
  input logic              wc_busy,
  input logic              pw_we,
  input logic              pw_open,
  input logic              pw_commit,
  input logic [ADDR_W-1:0] mem_addr
);
  AST_CTRL_CODE_MATCH: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_CTRL && state == ST_ACK) |-> $past(rx_byte[7:4]) == DEV_CODE); // R1

  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_CTRL && state == ST_ACK) |-> !$past(wc_busy)); // R10

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_lvl); // R2

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    pw_we |=> mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W])); // R4

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pw_we, pw_open, pw_commit})); // R5
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_lvl(scl_s), .state(state),
  .rx_byte(rx_byte), .wc_busy(wc_busy), .pw_we(pw_we), .pw_open(pw_open),
  .pw_commit(pw_commit), .mem_addr(mem_addr)
);

// File: tb/i2c_eeprom_slave_test.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_test;
  localparam int Q    = 8;
  localparam int BUSY = 2000;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_bus;
  logic [10:0] mem_addr, pw_addr;
  logic [7:0] mem_rdata = 8'h00, pw_wdata;
  logic pw_open, pw_we, pw_commit, wc_busy;

  int checks = 0, errors = 0, commits = 0, busy_cnt = 0;
  int ref_ptr = 0;
  logic [7:0] arr [0:2047];
  logic [7:0] ref_mem [0:2047];
  int qa[$];
  logic [7:0] qd[$];
  logic prev_oe = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;
  assign wc_busy = (busy_cnt != 0);

  i2c_eeprom_slave uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .pw_open(pw_open), .pw_we(pw_we),
    .pw_addr(pw_addr), .pw_wdata(pw_wdata), .pw_commit(pw_commit), .wc_busy(wc_busy)
  );

  // memory array and page-write controller of the bench
  always @(posedge clk) begin
    mem_rdata <= arr[mem_addr];
    if (pw_open) begin qa.delete(); qd.delete(); end
    if (pw_we) begin qa.push_back(int'(pw_addr)); qd.push_back(pw_wdata); end
    if (pw_commit) begin
      foreach (qa[i]) arr[qa[i]] <= qd[i];
      busy_cnt <= BUSY;
      commits  <= commits + 1;
    end else if (busy_cnt > 0) begin
      busy_cnt <= busy_cnt - 1;
    end
  end

  // per-clock check: SDA drive may change only while SCL is low (R2)
  always @(negedge clk) begin
    if (!rst && sda_oe !== prev_oe && scl_m) begin
      errors++;
      $display("FAIL R2 sda_oe changed with SCL high act=%b exp=%b", sda_oe, prev_oe);
    end
    prev_oe = sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wq; repeat (Q) @(negedge clk); endtask
  task automatic m_start; sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
  task automatic m_stop;  sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); wq(); endtask
  task automatic m_bit(input logic b, output logic r);
    sda_m = b; wq(); scl_m = 1; wq(); r = sda_bus; wq(); scl_m = 0; wq();
  endtask
  task automatic m_send(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(b[i], r);
    m_bit(1'b1, r);
    ack = ~r;
  endtask
  task automatic m_recv(input logic ack_it, output logic [7:0] d);
    logic r;
    for (int i = 0; i < 8; i++) begin m_bit(1'b1, r); d = {d[6:0], r}; end
    m_bit(~ack_it, r);
  endtask

  function automatic logic [7:0] ctl(input int blk, input logic rd);
    return {4'b1010, 3'(blk), rd};
  endfunction

  task automatic read_seq(input int n, input string req);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      m_recv(k != n - 1, d);
      chk(req, d, ref_mem[ref_ptr]);
      ref_ptr = (ref_ptr + 1) % 2048;
    end
  endtask

  task automatic page_write(input int blk, input int lo, input int n, input int seed);
    logic ack;
    int base;
    int c0;
    c0 = commits;
    m_start();
    m_send(ctl(blk, 0), ack); chk("R1 ctrl ack", ack, 1);
    m_send(8'(lo), ack);      chk("R3 addr ack", ack, 1);
    base = (blk << 8) | (lo & 8'hF0);
    for (int k = 0; k < n; k++) begin
      m_send(8'(seed + 17 * k), ack); chk("R4 data ack", ack, 1);
      ref_mem[base + ((lo + k) % 16)] = 8'(seed + 17 * k);
    end
    ref_ptr = base + ((lo + n) % 16);
    m_stop(); wq();
    chk("R5 one commit", commits, c0 + 1);
  endtask

  task automatic poll_ready(input int blk);
    logic ack;
    int c0;
    c0 = commits;
    m_start(); m_send(ctl(blk, 0), ack); m_stop();
    chk("R10 nack while busy", ack, 0);
    for (int t = 0; t < 40 && !ack; t++) begin
      m_start(); m_send(ctl(blk, 0), ack); m_stop();
    end
    chk("R10 ack after busy", ack, 1);
    ref_ptr = (blk << 8) | (ref_ptr & 8'hFF);
    wq();
    chk("R5 no commit on bare control", commits, c0);
  endtask

  task automatic rand_read(input int blk, input int lo, input int n, input string req);
    logic ack;
    int c0;
    c0 = commits;
    m_start();
    m_send(ctl(blk, 0), ack); m_send(8'(lo), ack);
    m_start();                                   // repeated Start, R6
    m_send(ctl(blk, 1), ack); chk("R6 read ctrl ack", ack, 1);
    ref_ptr = (blk << 8) | lo;
    read_seq(n, req);
    m_stop(); wq();
    chk("R6 no commit", commits, c0);
  endtask

  task automatic cur_read(input int blk, input int n, input string req);
    logic ack;
    m_start();
    m_send(ctl(blk, 1), ack); chk("R7 ctrl ack", ack, 1);
    ref_ptr = (blk << 8) | (ref_ptr & 8'hFF);
    read_seq(n, req);
    m_stop();
  endtask

  initial begin
    logic ack, r;
    logic [7:0] d;
    int c0;
    for (int i = 0; i < 2048; i++) begin
      arr[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 sda_oe", sda_oe, 0);
    chk("R12 pointer", mem_addr, 0);
    chk("R12 pulses", {pw_open, pw_we, pw_commit}, 0);

    // byte write, busy polling, current-address reads
    page_write(3, 8'h45, 1, 8'h5A);
    poll_ready(3);
    cur_read(3, 1, "R7 current read");
    cur_read(1, 1, "R7 block bits replaced");
    rand_read(3, 8'h45, 1, "R6 random read");

    // page write crossing the page end wraps inside the page
    page_write(5, 8'h5E, 4, 8'h21);
    poll_ready(5);
    rand_read(5, 8'h50, 4, "R4 page wrap low");
    rand_read(5, 8'h5E, 3, "R8 sequential");

    // NACK releases the bus until the next Start
    m_start(); m_send(ctl(2, 1), ack); ref_ptr = (2 << 8) | (ref_ptr & 8'hFF);
    read_seq(1, "R8 single byte");
    m_recv(1'b0, d);
    chk("R8 released after NACK", d, 8'hFF);
    m_stop();

    // wrong device code: silent until Start
    m_start();
    m_send(8'h52, ack); chk("R1 wrong code nack", ack, 0);
    m_send(8'h00, ack); chk("R1 still silent", ack, 0);
    m_stop();

    // full-space wrap of sequential read
    rand_read(7, 8'hFE, 3, "R9 wrap 7FF to 000");

    // Start inside a data byte aborts the write
    c0 = commits;
    m_start();
    m_send(ctl(2, 0), ack); m_send(8'h10, ack);
    m_send(8'h11, ack); chk("R11 first data ack", ack, 1);
    m_bit(1, r); m_bit(0, r); m_bit(1, r); m_bit(0, r);
    m_start();
    m_send(ctl(2, 1), ack); chk("R11 ctrl after abort", ack, 1);
    ref_ptr = 12'h211;
    read_seq(1, "R11 pointer moved");
    m_stop(); wq();
    chk("R11 no commit", commits, c0);
    rand_read(2, 8'h10, 1, "R11 memory unchanged");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule